// File: doc/BRIEF.md
# Bridge Secondary Status Register

This block holds the secondary-side error status word of a virtual PCI-to-PCI bridge that sits in front of a PCI Express link. Several error events can be seen on the downstream side: poisoned TLPs, fatal or non-fatal error messages, and abort completions for requests the bridge issued itself. Each event arrives as a single-cycle strobe and sets its own sticky flag. A flag stays set until software writes a 1 to its position through the configuration port.

The data-parity flag only records poisoned read completions while the parity error response enable from the bridge control register is 1. The general poisoned-TLP flag ignores that enable. The legacy timing and capability fields, and the reserved fields, always read as zero. The configuration port returns the assembled word combinationally. Writes are split into byte lanes by a two-bit byte enable.

Top module: `bridge_sec_status`

## Requirements
- R1: While `rst_n` is low, and on the first read after reset is released, `cfg_rdata` is 16'h0000.
- R2: A cycle with `ev_poison_tlp` = 1 sets bit 15 at the next clock edge, whatever the value of `perr_en`.
- R3: A cycle with `ev_err_msg` = 1 (a fatal or non-fatal error message was received) sets bit 14 at the next clock edge.
- R4: A cycle with `cpl_valid` = 1, `cpl_own` = 1 and `cpl_status` = 3'b001 (Unsupported Request) sets bit 13. The same cycle with `cpl_status` = 3'b100 (Completer Abort) sets bit 12. Any other status code, for example 3'b000 (Successful Completion), sets neither bit.
- R5: A completion with `cpl_own` = 0 sets neither bit 13 nor bit 12, whatever its status code.
- R6: Bit 8 sets only in a cycle where `ev_poison_rd_cpl` = 1 and `perr_en` = 1. A poisoned read completion with `perr_en` = 0 leaves bit 8 unchanged.
- R7: A write (`cfg_wr` = 1) clears each of bits 15, 14, 13, 12 and 8 whose `cfg_wdata` bit is 1 in an enabled byte lane. A written 0 leaves its bit unchanged.
- R8: `cfg_be[1]` enables bits 15:8 and `cfg_be[0]` enables bits 7:0. Data in a disabled lane has no effect.
- R9: When a set event and a write-1-to-clear hit the same bit in the same cycle, the bit is 1 afterwards.
- R10: Bits 11, 10:9, 7, 6, 5 and 4:0 always read 0, including after writes of all ones.
- R11: `cfg_rdata` is the current register value with zero added latency: a bit set or cleared at a clock edge is visible on `cfg_rdata` right after that edge. Without events or writes the value holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_poison_tlp | input | 1 | Poisoned TLP received on the secondary side |
| ev_poison_rd_cpl | input | 1 | Poisoned read-data completion received across the link |
| ev_err_msg | input | 1 | Fatal or non-fatal error message received |
| cpl_valid | input | 1 | A completion is presented this cycle |
| cpl_own | input | 1 | The completion answers a request the bridge itself issued |
| cpl_status | input | 3 | Completion status code (001 UR, 100 CA) |
| perr_en | input | 1 | Parity error response enable from the bridge control register |
| cfg_wr | input | 1 | Configuration write strobe for this register |
| cfg_be | input | 2 | Byte enables for the write |
| cfg_wdata | input | 16 | Write data, 1 clears a sticky bit |
| cfg_rdata | output | 16 | Current register value |

## Verification
On every cycle the assertions check the behaviour of each sticky cell: set beats clear, a lone clear empties the bit, and the bit holds when neither happens. They also check that the hardwired fields read zero, that bits 15 and 14 follow their strobes, and that bits 13 and 8 only rise after a qualifying own completion or an enabled poisoned read. The bench scenarios show what a single-cycle property cannot cover. These are the cumulative word over a sequence of mixed events, the byte-lane masking of writes, writes of zero, and a reset in the middle of a run that wipes flags which were set.

// File: rtl/bss_pkg.sv
package bss_pkg;
  localparam int REG_W  = 16;
  localparam int LANE_W = 8;
  localparam int BE_W   = REG_W / LANE_W;

  localparam logic [2:0] CPL_SC = 3'b000;
  localparam logic [2:0] CPL_UR = 3'b001;
  localparam logic [2:0] CPL_CA = 3'b100;

  localparam int B_DPE  = 15;
  localparam int B_RSE  = 14;
  localparam int B_RMA  = 13;
  localparam int B_RTA  = 12;
  localparam int B_MDPE = 8;

  localparam logic [REG_W-1:0] STICKY_MASK =
    (REG_W'(1) << B_DPE) | (REG_W'(1) << B_RSE) | (REG_W'(1) << B_RMA) |
    (REG_W'(1) << B_RTA) | (REG_W'(1) << B_MDPE);

  function automatic logic [REG_W-1:0] lane_mask(input logic [BE_W-1:0] be);
    logic [REG_W-1:0] m;
    for (int i = 0; i < REG_W; i++) m[i] = be[i / LANE_W];
    return m;
  endfunction

  function automatic logic [REG_W-1:0] clear_vector(input logic wr,
                                                     input logic [BE_W-1:0] be,
                                                     input logic [REG_W-1:0] wdata);
    return wr ? (wdata & lane_mask(be) & STICKY_MASK) : '0;
  endfunction
endpackage

// File: rtl/bss_event_decode.sv
module bss_event_decode
  import bss_pkg::*;
(
  input  logic             ev_poison_tlp,
  input  logic             ev_poison_rd_cpl,
  input  logic             ev_err_msg,
  input  logic             cpl_valid,
  input  logic             cpl_own,
  input  logic [2:0]       cpl_status,
  input  logic             perr_en,
  output logic [REG_W-1:0] set_vec
);
  logic own_cpl, own_ur, own_ca, mdpe_hit;

  assign own_cpl  = cpl_valid & cpl_own;
  assign own_ur   = own_cpl & (cpl_status == CPL_UR);
  assign own_ca   = own_cpl & (cpl_status == CPL_CA);
  assign mdpe_hit = ev_poison_rd_cpl & perr_en;

  always_comb begin
    set_vec         = '0;
    set_vec[B_DPE]  = ev_poison_tlp;
    set_vec[B_RSE]  = ev_err_msg;
    set_vec[B_RMA]  = own_ur;
    set_vec[B_RTA]  = own_ca;
    set_vec[B_MDPE] = mdpe_hit;
  end
endmodule

// File: rtl/bss_sticky_bit.sv
module bss_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o); // R9
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(q_o)); // R11
endmodule

// File: rtl/bridge_sec_status.sv
module bridge_sec_status
  import bss_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_poison_tlp,
  input  logic             ev_poison_rd_cpl,
  input  logic             ev_err_msg,
  input  logic             cpl_valid,
  input  logic             cpl_own,
  input  logic [2:0]       cpl_status,
  input  logic             perr_en,
  input  logic             cfg_wr,
  input  logic [BE_W-1:0]  cfg_be,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata
);
  logic [REG_W-1:0] set_vec;
  logic [REG_W-1:0] clr_vec;
  logic [REG_W-1:0] flag_q;

  bss_event_decode u_decode (
    .ev_poison_tlp   (ev_poison_tlp),
    .ev_poison_rd_cpl(ev_poison_rd_cpl),
    .ev_err_msg      (ev_err_msg),
    .cpl_valid       (cpl_valid),
    .cpl_own         (cpl_own),
    .cpl_status      (cpl_status),
    .perr_en         (perr_en),
    .set_vec         (set_vec)
  );

  assign clr_vec = clear_vector(cfg_wr, cfg_be, cfg_wdata);

  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    if (STICKY_MASK[i]) begin : g_sticky
      bss_sticky_bit u_bit (
        .clk  (clk),
        .rst_n(rst_n),
        .set_i(set_vec[i]),
        .clr_i(clr_vec[i]),
        .q_o  (flag_q[i])
      );
    end else begin : g_zero
      assign flag_q[i] = 1'b0;
    end
  end

  assign cfg_rdata = flag_q;

  AST_RESET_ZERO: assert property (@(posedge clk)
    !rst_n |=> (cfg_rdata == '0)); // R1
  AST_HW_ZERO: assert property (@(posedge clk)
    (cfg_rdata & ~STICKY_MASK) == '0); // R10
  AST_DPE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_poison_tlp |=> cfg_rdata[B_DPE]); // R2
  AST_RSE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_err_msg |=> cfg_rdata[B_RSE]); // R3
  AST_RMA_OWN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_rdata[B_RMA]) |-> $past(cpl_valid && cpl_own && cpl_status == CPL_UR)); // R5
  AST_RTA_OWN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_rdata[B_RTA]) |-> $past(cpl_valid && cpl_own && cpl_status == CPL_CA)); // R4
  AST_MDPE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_rdata[B_MDPE]) |-> $past(ev_poison_rd_cpl && perr_en)); // R6
endmodule

// File: tb/bridge_sec_status_tb_top.sv
module bridge_sec_status_tb_top;
  typedef struct packed {
    logic        poison;
    logic        prd;
    logic        emsg;
    logic        cv;
    logic        own;
    logic [2:0]  st;
    logic        pe;
    logic        wr;
    logic [1:0]  be;
    logic [15:0] wd;
    logic [15:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1,0,0,0,0,3'b000,0,0,2'b00,16'h0000,16'h8000,4'd2},
    '{0,0,1,0,0,3'b000,0,0,2'b00,16'h0000,16'hC000,4'd3},
    '{0,0,0,1,1,3'b001,0,0,2'b00,16'h0000,16'hE000,4'd4},
    '{0,0,0,1,1,3'b100,0,0,2'b00,16'h0000,16'hF000,4'd4},
    '{0,0,0,0,0,3'b000,0,1,2'b11,16'hFFFF,16'h0000,4'd7},
    '{0,0,0,1,0,3'b001,0,0,2'b00,16'h0000,16'h0000,4'd5},
    '{0,0,0,1,0,3'b100,0,0,2'b00,16'h0000,16'h0000,4'd5},
    '{0,1,0,0,0,3'b000,0,0,2'b00,16'h0000,16'h0000,4'd6},
    '{0,1,0,0,0,3'b000,1,0,2'b00,16'h0000,16'h0100,4'd6},
    '{0,0,0,1,1,3'b000,0,0,2'b00,16'h0000,16'h0100,4'd4},
    '{0,0,0,0,0,3'b000,0,1,2'b01,16'hFFFF,16'h0100,4'd8},
    '{0,0,0,0,0,3'b000,0,1,2'b10,16'h0000,16'h0100,4'd7},
    '{0,0,0,0,0,3'b000,0,1,2'b10,16'h0100,16'h0000,4'd8},
    '{1,0,1,0,0,3'b000,0,0,2'b00,16'h0000,16'hC000,4'd2},
    '{0,0,0,0,0,3'b000,0,1,2'b10,16'h4000,16'h8000,4'd7},
    '{1,0,0,0,0,3'b000,0,1,2'b10,16'hFFFF,16'h8000,4'd9},
    '{0,0,0,0,0,3'b000,0,1,2'b11,16'hFFFF,16'h0000,4'd7}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ev_poison_tlp, ev_poison_rd_cpl, ev_err_msg;
  logic        cpl_valid, cpl_own, perr_en, cfg_wr;
  logic [2:0]  cpl_status;
  logic [1:0]  cfg_be;
  logic [15:0] cfg_wdata, cfg_rdata;
  int          n_checks = 0;
  int          n_errors = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  bridge_sec_status dut_i (
    .clk(clk), .rst_n(rst_n),
    .ev_poison_tlp(ev_poison_tlp), .ev_poison_rd_cpl(ev_poison_rd_cpl),
    .ev_err_msg(ev_err_msg), .cpl_valid(cpl_valid), .cpl_own(cpl_own),
    .cpl_status(cpl_status), .perr_en(perr_en), .cfg_wr(cfg_wr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: cfg_rdata=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    ev_poison_tlp = 0; ev_poison_rd_cpl = 0; ev_err_msg = 0;
    cpl_valid = 0; cpl_own = 0; cpl_status = 3'b000; perr_en = 0;
    cfg_wr = 0; cfg_be = 2'b00; cfg_wdata = 16'h0000;
  endtask

  task automatic drive(input vec_t v);
    ev_poison_tlp = v.poison; ev_poison_rd_cpl = v.prd; ev_err_msg = v.emsg;
    cpl_valid = v.cv; cpl_own = v.own; cpl_status = v.st; perr_en = v.pe;
    cfg_wr = v.wr; cfg_be = v.be; cfg_wdata = v.wd;
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 1'b0;
    @(negedge clk);
    chk(cfg_rdata, 16'h0000, "R1 during reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cfg_rdata, 16'h0000, "R1 after reset");

    // table walk: drive at one falling edge, sample at the next
    for (int k = 0; k < NV; k++) begin
      drive(VEC[k]);
      @(negedge clk);
      idle();
      chk(cfg_rdata, VEC[k].exp, $sformatf("R%0d vector %0d", VEC[k].req, k));
    end

    // R11: value visible right after the edge, then holds
    ev_err_msg = 1;
    @(posedge clk);
    #1 chk(cfg_rdata, 16'h4000, "R11 visible after edge");
    @(negedge clk);
    idle();
    repeat (3) @(negedge clk);
    chk(cfg_rdata, 16'h4000, "R11 hold without events");

    // R10: everything set, all-ones writes on the low lane, zero fields stay 0
    ev_poison_tlp = 1; ev_poison_rd_cpl = 1; perr_en = 1;
    cpl_valid = 1; cpl_own = 1; cpl_status = 3'b001;
    @(negedge clk);
    idle();
    cpl_valid = 1; cpl_own = 1; cpl_status = 3'b100;
    @(negedge clk);
    idle();
    chk(cfg_rdata, 16'hF100, "R10 all sticky set");
    cfg_wr = 1; cfg_be = 2'b01; cfg_wdata = 16'hFFFF;
    @(negedge clk);
    idle();
    chk(cfg_rdata & 16'h0EFF, 16'h0000, "R10 hardwired zero fields");
    chk(cfg_rdata, 16'hF100, "R8 low lane write clears nothing");

    // R9: set and clear of bit 8 in the same cycle
    ev_poison_rd_cpl = 1; perr_en = 1;
    cfg_wr = 1; cfg_be = 2'b11; cfg_wdata = 16'hFFFF;
    @(negedge clk);
    idle();
    chk(cfg_rdata, 16'h0100, "R9 set beats clear on bit 8");

    // R2: poisoned TLP sets bit 15 with enable asserted too
    ev_poison_tlp = 1; perr_en = 1;
    @(negedge clk);
    idle();
    chk(cfg_rdata, 16'h8100, "R2 poison with enable");

    // R1: reset in mid run wipes the flags
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cfg_rdata, 16'h0000, "R1 mid-run reset");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule